// File: doc/BRIEF.md
# Look-ahead pipelined first-order recursive filter

This block is a streaming one-pole recursive filter that takes one signed sample per clock. Its output follows y[n] = a·y[n-1] + x[n]. The recursion is unfolded M times, giving y[n] = a^M·y[n-M] + Σ a^i·x[n-i] for i from 0 to M-1. The feedback loop therefore spans M sample delays, and the multiply-add inside the loop can be pipelined without changing the result.

The datapath has three parts. The first is a non-recursive pre-filter that weights the newest M input samples by a^0 to a^(M-1). The second is a recursive loop that scales a delayed output by a^M; for M of 2 or more, one loop delay is moved behind the multiplier. The third is an output stage that rounds and saturates back to the input format.

All coefficient powers are rounded fixed-point constants computed at elaboration from a single coefficient parameter. A valid strobe travels with the data. Cycles without a valid input leave every piece of filter state untouched.

Top module: `la_iir`

## Requirements
- R1: While reset is asserted, and until the first accepted sample has travelled through, out_valid is 0 and out_data is 0. All history and loop state starts from zero, so the first outputs after reset equal the response of a filter at rest.
- R2: Samples are two's complement Q1.15 (value = code/32768), and the coefficient parameter A_Q encodes a = A_Q/32768 with |A_Q| < 32768. For a coefficient whose powers up to M are exact in Q1.15, each output equals round-half-up(32768·y[n]) of the ideal recursion y[n] = a·y[n-1] + x[n], saturated to 16 bits, within 1 LSB.
- R3: An impulse of amplitude X followed by zeros produces outputs X·a^k, k = 0, 1, 2, …, within 1 LSB.
- R4: A constant input X produces a step response that settles at X/(1-a), within 1 LSB.
- R5: An ideal result above 32767 LSB is output as 32767 (0x7FFF). A result below -32768 LSB is output as -32768 (0x8000).
- R6: A sample accepted at a rising edge with in_valid high yields exactly one result, with out_valid high, after the second rising edge that follows. Outputs appear in input order, and no output appears without an input.
- R7: In a cycle with in_valid low, in_data is ignored and no filter state advances. out_valid is low and out_data holds its last value until the next accepted sample comes through.
- R8: The loop depth parameter M (≥ 1) changes only the internal structure. Instances with M = 1, 2 and 4 all meet R2 to R7 on the same input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| in_valid | input | 1 | The sample on in_data is accepted in this cycle |
| in_data | input | DW | Signed Q1.15 input sample |
| out_valid | output | 1 | out_data carries a new filtered sample |
| out_data | output | DW | Signed Q1.15 filtered sample, rounded and saturated |

## Verification
Three instances run side by side on the same stream: M = 1 and M = 2 with a = 0.5, and M = 4 with a = -0.75. Each instance's outputs are compared with a real-valued model of the plain one-pole recursion. An impulse exposes a wrong coefficient power or wrong loop spacing, because each tap and each loop delay shows up at its own output index. A step checks the settled gain and the build-up of the loop. Large constant and alternating inputs drive both saturation limits, with positive and negative coefficients. Random samples separated by stall cycles carrying junk data show whether a stall leaks into the filter state or the output.

// File: rtl/la_iir_pkg.sv
package la_iir_pkg;

  // Rounded fixed-point power a^n, with a given as a code carrying fb fraction bits.
  function automatic longint coef_pow(longint a_code, int n, int fb);
    longint p;
    p = longint'(1) <<< fb;
    for (int k = 0; k < n; k++) begin
      p = (p * a_code + (longint'(1) <<< (fb - 1))) >>> fb;
    end
    return p;
  endfunction

  // Extra accumulator headroom for an M-term sum.
  function automatic int guard_bits(int m);
    return $clog2(m) + 2;
  endfunction

endpackage

// File: rtl/la_iir_rstsync.sv
module la_iir_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/la_iir_prefilter.sv
module la_iir_prefilter
  import la_iir_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CW  = 18,
  parameter int FB  = 15,
  parameter int AW  = 37,
  parameter int M   = 2,
  parameter int A_Q = 16384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 w_valid,
  output logic signed [AW-1:0] w_data
);

  localparam int PW = DW + CW;

  logic signed [DW-1:0] tap  [M];
  logic signed [PW-1:0] prod [M];
  logic signed [AW-1:0] acc_nxt;
  logic signed [AW-1:0] acc_q;
  logic                 v_q;

  assign tap[0] = in_data;

  // Input history: only present when the pre-filter has more than one tap.
  generate
    if (M > 1) begin : g_hist
      logic signed [DW-1:0] hist_q   [M-1];
      logic signed [DW-1:0] hist_nxt [M-1];

      always_comb begin
        hist_nxt[0] = in_data;
        for (int k = 1; k < M - 1; k++) begin
          hist_nxt[k] = hist_q[k-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < M - 1; k++) begin
            hist_q[k] <= '0;
          end
        end else if (in_valid) begin
          hist_q <= hist_nxt;
        end
      end

      for (genvar i = 1; i < M; i++) begin : g_tap
        assign tap[i] = hist_q[i-1];
      end
    end
  endgenerate

  // One constant multiplier per tap, weight a^i.
  generate
    for (genvar i = 0; i < M; i++) begin : g_mul
      localparam logic signed [CW-1:0] CI = CW'(coef_pow(A_Q, i, FB));
      assign prod[i] = tap[i] * CI;
    end
  endgenerate

  always_comb begin
    acc_nxt = '0;
    for (int i = 0; i < M; i++) begin
      acc_nxt = acc_nxt + AW'(prod[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        acc_q <= acc_nxt;
      end
    end
  end

  assign w_valid = v_q;
  assign w_data  = acc_q;

endmodule

// File: rtl/la_iir_loop.sv
module la_iir_loop
  import la_iir_pkg::*;
#(
  parameter int CW  = 18,
  parameter int FB  = 15,
  parameter int AW  = 37,
  parameter int M   = 2,
  parameter int A_Q = 16384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 w_valid,
  input  logic signed [AW-1:0] w_data,
  output logic                 y_valid,
  output logic signed [AW-1:0] y_data
);

  localparam int PW = AW + CW;
  localparam logic signed [CW-1:0] AM = CW'(coef_pow(A_Q, M, FB));

  logic signed [AW-1:0] y_q;
  logic signed [AW-1:0] y_nxt;
  logic signed [AW-1:0] fb_term;
  logic                 v_q;

  // Multiply by a^M, round away FB fraction bits, keep the accumulator width.
  function automatic logic signed [AW-1:0] scale_am(input logic signed [AW-1:0] v);
    logic signed [PW-1:0] p;
    p = v * AM;
    p = p + (PW'(1) <<< (FB - 1));
    return AW'(p >>> FB);
  endfunction

  generate
    if (M == 1) begin : g_direct
      // Single loop delay: the multiplier sits in the loop with the adder.
      assign fb_term = scale_am(y_q);
    end else if (M == 2) begin : g_retimed_short
      // One loop delay is moved behind the multiplier.
      logic signed [AW-1:0] prod_q;
      logic signed [AW-1:0] prod_nxt;

      always_comb begin
        prod_nxt = scale_am(y_q);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q <= '0;
        end else if (w_valid) begin
          prod_q <= prod_nxt;
        end
      end

      assign fb_term = prod_q;
    end else begin : g_retimed_long
      // Delay chain between the output register and the product register.
      logic signed [AW-1:0] dly_q   [M-2];
      logic signed [AW-1:0] dly_nxt [M-2];
      logic signed [AW-1:0] prod_q;
      logic signed [AW-1:0] prod_nxt;

      always_comb begin
        dly_nxt[0] = y_q;
        for (int k = 1; k < M - 2; k++) begin
          dly_nxt[k] = dly_q[k-1];
        end
        prod_nxt = scale_am(dly_q[M-3]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < M - 2; k++) begin
            dly_q[k] <= '0;
          end
          prod_q <= '0;
        end else if (w_valid) begin
          dly_q  <= dly_nxt;
          prod_q <= prod_nxt;
        end
      end

      assign fb_term = prod_q;
    end
  endgenerate

  always_comb begin
    y_nxt = fb_term + w_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= w_valid;
      if (w_valid) begin
        y_q <= y_nxt;
      end
    end
  end

  assign y_valid = v_q;
  assign y_data  = y_q;

endmodule

// File: rtl/la_iir_outstage.sv
module la_iir_outstage #(
  parameter int DW = 16,
  parameter int FB = 15,
  parameter int AW = 37
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 y_valid,
  input  logic signed [AW-1:0] y_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [AW-1:0] rnd;
  logic signed [DW-1:0] sat_nxt;
  logic signed [DW-1:0] data_q;
  logic                 v_q;

  always_comb begin
    rnd = (y_data + (AW'(1) <<< (FB - 1))) >>> FB;
    if (rnd > AW'(MAXV)) begin
      sat_nxt = MAXV;
    end else if (rnd < AW'(MINV)) begin
      sat_nxt = MINV;
    end else begin
      sat_nxt = rnd[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= y_valid;
      if (y_valid) begin
        data_q <= sat_nxt;
      end
    end
  end

  assign out_valid = v_q;
  assign out_data  = data_q;

endmodule

// File: rtl/la_iir.sv
module la_iir
  import la_iir_pkg::*;
#(
  parameter int DW  = 16,
  parameter int M   = 2,
  parameter int A_Q = 16384
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int FB = DW - 1;
  localparam int CW = DW + 2;
  localparam int GB = guard_bits(M);
  localparam int AW = DW + CW + GB;

  logic                 rst_n_sync;
  logic                 pre_v;
  logic signed [AW-1:0] pre_w;
  logic                 loop_v;
  logic signed [AW-1:0] loop_y;

  la_iir_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  la_iir_prefilter #(
    .DW(DW), .CW(CW), .FB(FB), .AW(AW), .M(M), .A_Q(A_Q)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_valid (in_valid),
    .in_data  (in_data),
    .w_valid  (pre_v),
    .w_data   (pre_w)
  );

  la_iir_loop #(
    .CW(CW), .FB(FB), .AW(AW), .M(M), .A_Q(A_Q)
  ) u_loop (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .w_valid (pre_v),
    .w_data  (pre_w),
    .y_valid (loop_v),
    .y_data  (loop_y)
  );

  la_iir_outstage #(
    .DW(DW), .FB(FB), .AW(AW)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .y_valid   (loop_v),
    .y_data    (loop_y),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/la_iir_chk.sv
module la_iir_chk #(
  parameter int DW = 16,
  parameter int AW = 37
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 vin,
  input logic                 vout,
  input logic signed [DW-1:0] dout,
  input logic                 pre_v,
  input logic signed [AW-1:0] pre_w,
  input logic signed [AW-1:0] loop_y
);

  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 2'd0;
    end else if (seen != 2'd3) begin
      seen <= seen + 2'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!vout && dout == '0); // R1
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (vout == $past(vin, 3))); // R6

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 2'd0 && !vout) |-> $stable(dout)); // R7

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !vin |=> $stable(pre_w)); // R7

  AST_LOOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_v |=> $stable(loop_y)); // R7

endmodule

bind la_iir la_iir_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .vin    (in_valid),
  .vout   (out_valid),
  .dout   (out_data),
  .pre_v  (pre_v),
  .pre_w  (pre_w),
  .loop_y (loop_y)
);

// File: tb/la_iir_test.sv
`timescale 1ns/1ps
module la_iir_test;

  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               out_valid_w [NI];
  logic signed [15:0] out_data_w  [NI];

  real   aref [NI];
  real   yref [NI];
  int    exp_q [NI][$];
  int    cyc_q [NI][$];
  string tag_q [NI][$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int m, int got, int expv, int tol);
    checks++;
    if (got - expv > tol || expv - got > tol) begin
      errors++;
      $display("FAIL %s M=%0d: got %0d expected %0d", tag, m, got, expv);
    end
  endtask

  function automatic int quant(real y);
    real r;
    r = $floor(y * 32768.0 + 0.5);
    if (r > 32767.0) r = 32767.0;
    if (r < -32768.0) r = -32768.0;
    return $rtoi(r);
  endfunction

  generate
    for (genvar g = 0; g < NI; g++) begin : g_dut
      localparam int MM = (g == 0) ? 1 : ((g == 1) ? 2 : 4);
      localparam int AQ = (g == 2) ? -24576 : 16384;
      logic signed [15:0] last;

      la_iir #(.DW(16), .M(MM), .A_Q(AQ)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid_w[g]),
        .out_data  (out_data_w[g])
      );

      // Monitor: pops the scoreboard as results come out.
      always @(negedge clk) begin
        if (!rst_n) begin
          last = '0;
        end else if (out_valid_w[g]) begin
          if (exp_q[g].size() == 0) begin
            check("R6 unexpected output", MM, 1, 0, 0);
          end else begin
            int    e;
            int    c;
            string t;
            e = exp_q[g].pop_front();
            c = cyc_q[g].pop_front();
            t = tag_q[g].pop_front();
            check(t, MM, int'(out_data_w[g]), e, 1);
            check("R6 latency", MM, cyc - c, 3, 0);
          end
          last = out_data_w[g];
        end else begin
          check("R7 hold", MM, int'(out_data_w[g]), int'(last), 0);
        end
      end
    end
  endgenerate

  // Driver: applies a sample and pushes the model's expected output.
  task automatic send(int x, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(x);
    for (int g = 0; g < NI; g++) begin
      yref[g] = aref[g] * yref[g] + real'(x) / 32768.0;
      exp_q[g].push_back(quant(yref[g]));
      cyc_q[g].push_back(cyc);
      tag_q[g].push_back(tag);
    end
  endtask

  task automatic pause(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'($urandom());
    end
  endtask

  task automatic do_reset();
    pause(6);
    @(negedge clk);
    rst_n = 1'b0;
    for (int g = 0; g < NI; g++) yref[g] = 0.0;
    @(negedge clk);
    for (int g = 0; g < NI; g++) begin
      check("R1 reset valid", g, int'(out_valid_w[g]), 0, 0);
      check("R1 reset data", g, int'(out_data_w[g]), 0, 0);
    end
    pause(2);
    rst_n = 1'b1;
    pause(3);
  endtask

  initial begin
    aref[0] = 0.5;
    aref[1] = 0.5;
    aref[2] = -0.75;
    for (int g = 0; g < NI; g++) yref[g] = 0.0;
    pause(3);
    for (int g = 0; g < NI; g++) begin
      check("R1 reset valid", g, int'(out_valid_w[g]), 0, 0);
      check("R1 reset data", g, int'(out_data_w[g]), 0, 0);
    end
    rst_n = 1'b1;
    pause(3);

    // R3: impulse, first outputs from the rest state (R1)
    send(16384, "R3 R1");
    for (int k = 0; k < 24; k++) send(0, "R3");
    pause(4);

    // R4: step
    do_reset();
    for (int k = 0; k < 40; k++) send(8192, "R4");

    // R7: stalls with junk data between samples
    do_reset();
    for (int k = 0; k < 40; k++) begin
      send(int'($urandom_range(32000)) - 16000, "R7");
      pause(int'($urandom_range(3, 1)));
    end

    // R5: saturation at both limits
    do_reset();
    for (int k = 0; k < 20; k++) send(30000, "R5");
    for (int k = 0; k < 20; k++) send(-30000, "R5");
    for (int k = 0; k < 20; k++) send((k % 2 == 0) ? 30000 : -30000, "R5");

    // R2, R8: random stream across all loop depths
    do_reset();
    for (int k = 0; k < 400; k++) begin
      send(int'($urandom_range(40000)) - 20000, "R2 R8");
      if ($urandom_range(9) == 0) pause(int'($urandom_range(2, 1)));
    end

    pause(10);
    for (int g = 0; g < NI; g++) begin
      check("R6 leftover", g, exp_q[g].size(), 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: got no end expected end within 200000 cycles");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule